// File: doc/BRIEF.md
# Two-Wire Serial Port with Firmware-Driven Master and Hardware Slave

This block is a byte-oriented two-wire (I2C) peripheral for a small microcontroller. Firmware reaches it through three byte-wide registers on a simple write-strobe bus with combinational read data. These are a control register, an own-address register and a data register. A single mode bit in the control register chooses between two ways of running the bus.

In software-master mode, firmware drives the clock and data lines bit by bit through four control bits and reads the data line back through a captured input bit. In hardware-slave mode, a state machine watches the synchronized lines for START and STOP. It matches its own 7-bit address, receives or transmits bytes most significant bit first, and drives the acknowledge bit. It raises an interrupt flag once per data byte. Both lines are open-drain: each output pulls its line low when asserted and otherwise leaves it to the pull-up. An external SPI-enable input takes the shared pins away from this block.

The slave state machine has eight states:
- IDLE: bus free or engine held.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging a match.
- RX: shifting in a data byte.
- RX_ACK: acknowledging a received byte.
- TX: shifting out a data byte.
- TX_ACK: reading the master's acknowledge.
- SKIP: not addressed, or the master refused a byte.

The transitions are:
- START in any state goes to ADDR. STOP in any state goes to IDLE.
- Holding the engine (reset bit, master mode or SPI enable) forces IDLE.
- ADDR goes to ADDR_ACK on a match and to SKIP on a mismatch.
- ADDR_ACK goes to RX or TX, as the R/W bit selects.
- RX goes to RX_ACK, and RX_ACK returns to RX.
- TX goes to TX_ACK. TX_ACK returns to TX on ACK and goes to SKIP on NACK.

Top module: `i2c_sfr_port`

## Requirements
- R1: After reset the control register (offset 0) reads 0x00, the own-address register (offset 1) reads 0x55, the data register (offset 2) reads 0x00, and neither line is pulled low.
- R2: With the mode bit (control bit 3) at 1 and SPI enable low, SCL is pulled low exactly when the clock-out bit (control bit 5) is 0, and the slave engine never pulls SCL low.
- R3: In master mode SDA is pulled low exactly when the data-enable bit (control bit 6) is 1 and the data-out bit (control bit 7) is 0; with data-enable 0, SDA is released.
- R4: In master mode with data-enable 0, the data-in bit (control bit 4, read-only) takes the synchronized SDA level at each rising SCL edge. With data-enable 1, or with no rising SCL edge, it keeps its value.
- R5: While SPI enable is high, both lines are released in every mode, and a matching address gets no acknowledge.
- R6: After a START, the first 7 bits received are compared with bits 7..1 of the own-address register. On a match, SDA is held low through the 9th clock. On a mismatch, SDA stays released until the next START or STOP.
- R7: On an address match, the direction bit (control bit 1, read-only) takes the R/W bit of the address byte (1 means the slave transmits).
- R8: In receive, each data byte is assembled MSB first and written to the data register. The interrupt flag (control bit 0) is set, and the byte is acknowledged on its 9th clock.
- R9: In transmit, the data register value is shifted out MSB first and reloaded after each master ACK. The flag is set on the master's acknowledge clock. After a NACK, SDA stays released.
- R10: The interrupt flag is set only by the engine. A control-register write with bit 0 at 0 clears it; a write with bit 0 at 1 leaves it unchanged.
- R11: While the engine-reset bit (control bit 2) is 1, the slave ignores the bus. After it returns to 0, addressing works again.
- R12: A new value written to the own-address register is used for the next address comparison.
- R13: A repeated START in the middle of a transfer restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 own address, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected offset |
| spi_en | input | 1 | Shared pins taken by the SPI port; releases both lines |
| scl_in | input | 1 | Level seen on the SCL line |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
A wrong slave state shows at SDA on the very next bit. A lost address match or a miscounted bit either drops the acknowledge on the 9th clock or lets a pulled-low data bit appear where the master expects the line released. The bench samples the line in the middle of every high clock phase, so the fault is seen within one bit time. Wrong flag, direction or data contents show on the register read that follows each byte. Master-mode faults show on the line outputs within two core cycles of the control write.

// File: rtl/i2c_sfr_pkg.sv
package i2c_sfr_pkg;

    // register offsets on the firmware bus
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] REG_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] REG_SELF = 2'd1;
    localparam logic [REG_AW-1:0] REG_DATA = 2'd2;

    // control register bit positions
    localparam int CB_DOUT   = 7;
    localparam int CB_DEN    = 6;
    localparam int CB_COUT   = 5;
    localparam int CB_DIN    = 4;
    localparam int CB_MASTER = 3;
    localparam int CB_ERST   = 2;
    localparam int CB_DIR    = 1;
    localparam int CB_FLAG   = 0;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } slv_state_t;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        scl_rise  =  scl_s && !scl_p;
        scl_fall  = !scl_s &&  scl_p;
        // data moves while clock stays high
        bus_start =  scl_s && scl_p && sda_p && !sda_s;
        bus_stop  =  scl_s && scl_p && !sda_p && sda_s;
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_s,
    input  logic [6:0]        own_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_low,
    output logic              rx_strobe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              flag_set,
    output logic              dir_wr,
    output logic              dir_val
);

    slv_state_t        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic              phase_q, phase_n;
    logic              rw_q, rw_n;
    logic [BYTE_W-1:0] shifted_in;

    assign shifted_in = {sh_q[BYTE_W-2:0], sda_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            phase_q <= 1'b0;
            rw_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            phase_q <= phase_n;
            rw_q    <= rw_n;
        end
    end

    // next state and event pulses
    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        sh_n      = sh_q;
        phase_n   = phase_q;
        rw_n      = rw_q;
        rx_strobe = 1'b0;
        rx_byte   = shifted_in;
        flag_set  = 1'b0;
        dir_wr    = 1'b0;
        dir_val   = sda_s;
        if (hold || bus_stop) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            phase_n = 1'b0;
        end else if (bus_start) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
            phase_n = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_n  = shifted_in;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                            if (sh_q[6:0] == own_addr) begin
                                dir_wr  = 1'b1;
                                rw_n    = sda_s;
                                phase_n = 1'b0;
                                state_n = ST_ADDR_ACK;
                            end else begin
                                state_n = ST_SKIP;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            phase_n = 1'b1;
                        end else begin
                            phase_n = 1'b0;
                            cnt_n   = '0;
                            if (state_q == ST_ADDR_ACK && rw_q) begin
                                sh_n    = tx_byte;
                                state_n = ST_TX;
                            end else begin
                                state_n = ST_RX;
                            end
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh_n  = shifted_in;
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                            rx_strobe = 1'b1;
                            flag_set  = 1'b1;
                            phase_n   = 1'b0;
                            state_n   = ST_RX_ACK;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == CNT_W'(BYTE_W)) begin
                            phase_n = 1'b0;
                            state_n = ST_TX_ACK;
                        end else begin
                            sh_n = {sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        flag_set = 1'b1;
                        if (!sda_s) phase_n = 1'b1;
                        else        state_n = ST_SKIP;
                    end else if (scl_fall && phase_q) begin
                        phase_n = 1'b0;
                        cnt_n   = '0;
                        sh_n    = tx_byte;
                        state_n = ST_TX;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // line output
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_RX_ACK: sda_low = phase_q;
            ST_TX:                  sda_low = !sh_q[BYTE_W-1];
            default:                sda_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_sfr_port.sv
module i2c_sfr_port
    import i2c_sfr_pkg::*;
#(
    parameter logic [7:0] OWN_ADDR_RST = 8'h55,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              spi_en,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    logic bb_dout, bb_den, bb_cout, bb_din;
    logic sw_master, eng_rst, dir_q, flag_q;
    logic [7:0] ctrl_q;
    logic [7:0] self_q;
    logic [BYTE_W-1:0] data_q;

    logic fsm_sda_low, fsm_rx_strobe, fsm_flag_set, fsm_dir_wr, fsm_dir_val;
    logic [BYTE_W-1:0] fsm_rx_byte;
    logic engine_hold;

    i2c_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout ({scl_s, sda_s})
    );

    i2c_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    assign engine_hold = eng_rst || sw_master || spi_en;

    i2c_slave_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (engine_hold),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .sda_s    (sda_s),
        .own_addr (self_q[7:1]),
        .tx_byte  (data_q),
        .sda_low  (fsm_sda_low),
        .rx_strobe(fsm_rx_strobe),
        .rx_byte  (fsm_rx_byte),
        .flag_set (fsm_flag_set),
        .dir_wr   (fsm_dir_wr),
        .dir_val  (fsm_dir_val)
    );

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bb_dout   <= 1'b0;
            bb_den    <= 1'b0;
            bb_cout   <= 1'b0;
            bb_din    <= 1'b0;
            sw_master <= 1'b0;
            eng_rst   <= 1'b0;
            dir_q     <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_CTRL) begin
                bb_dout   <= reg_wdata[CB_DOUT];
                bb_den    <= reg_wdata[CB_DEN];
                bb_cout   <= reg_wdata[CB_COUT];
                sw_master <= reg_wdata[CB_MASTER];
                eng_rst   <= reg_wdata[CB_ERST];
                if (!reg_wdata[CB_FLAG]) flag_q <= 1'b0;
            end
            if (fsm_flag_set) flag_q <= 1'b1;
            if (fsm_dir_wr)   dir_q  <= fsm_dir_val;
            if (sw_master && !bb_den && scl_rise) bb_din <= sda_s;
        end
    end

    // own address and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            self_q <= OWN_ADDR_RST;
            data_q <= '0;
        end else begin
            if (reg_wr && reg_addr == REG_SELF) self_q <= reg_wdata;
            if (fsm_rx_strobe)
                data_q <= fsm_rx_byte;
            else if (reg_wr && reg_addr == REG_DATA)
                data_q <= reg_wdata;
        end
    end

    assign ctrl_q = {bb_dout, bb_den, bb_cout, bb_din, sw_master, eng_rst, dir_q, flag_q};

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = ctrl_q;
            REG_SELF: reg_rdata = self_q;
            REG_DATA: reg_rdata = data_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    // open-drain line control
    always_comb begin
        scl_drive_low = !spi_en && sw_master && !bb_cout;
        sda_drive_low = !spi_en && (sw_master ? (bb_den && !bb_dout) : fsm_sda_low);
    end

endmodule

// File: rtl/i2c_sfr_port_chk.sv
module i2c_sfr_port_chk
    import i2c_sfr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              spi_en,
    input logic              scl_drive_low,
    input logic              sda_drive_low,
    input logic [7:0]        ctrl,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr
);

    // R5
    spi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (!scl_drive_low && !sda_drive_low));

    // R2
    master_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_MASTER] && !spi_en) |-> (scl_drive_low == !ctrl[CB_COUT]));

    // R2
    slave_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_MASTER] |-> !scl_drive_low);

    // R3
    master_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_MASTER] && !ctrl[CB_DEN]) |-> !sda_drive_low);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_FLAG] && !(reg_wr && reg_addr == REG_CTRL)) |=> ctrl[CB_FLAG]);

    // R11
    eng_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_ERST] && !ctrl[CB_MASTER]) |=> (!sda_drive_low || ctrl[CB_MASTER]));

endmodule

bind i2c_sfr_port i2c_sfr_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_en       (spi_en),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .ctrl         (ctrl_q),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr)
);

// File: tb/i2c_sfr_port_test.sv
`timescale 1ns/1ps
module i2c_sfr_port_test;

    localparam int Q = 5;
    localparam logic [6:0] SELF7 = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_en = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_line, sda_line;
    logic       scl_drive_low, sda_drive_low;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_sfr_port uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .spi_en       (spi_en),
        .scl_in       (scl_line),
        .sda_in       (sda_line),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        @(negedge clk) sda_m = b;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        s = sda_line;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_start();
        @(negedge clk) sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_restart();
        @(negedge clk) sda_m = 1'b1;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
        wait_q();
    endtask

    task automatic bus_stop();
        @(negedge clk) sda_m = 1'b0;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
    endtask

    // returns 1 when the slave acknowledged
    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], s);
        xfer_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s);
            d[i] = s;
        end
    endtask

    task automatic addr_only(input logic [6:0] a, output logic acked);
        bus_start();
        send_byte({a, 1'b0}, acked);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        logic       ack;
        logic       s;
        logic [7:0] b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset values
        reg_read(2'd0, r); check("R1 ctrl", r, 8'h00);
        reg_read(2'd1, r); check("R1 own addr", r, 8'h55);
        reg_read(2'd2, r); check("R1 data", r, 8'h00);
        check("R1 lines", {6'd0, scl_drive_low, sda_drive_low}, 8'h00);

        // R2 R3 R5: sweep of line-control bits, SPI enable and mode bit
        for (int v = 0; v < 32; v++) begin
            logic dout, den, cout, spi, mst;
            {mst, spi, dout, den, cout} = 5'(v);
            reg_write(2'd0, {dout, den, cout, 1'b0, mst, 3'b000});
            spi_en = spi;
            repeat (3) @(negedge clk);
            check("R2 scl pull", {7'd0, scl_drive_low}, {7'd0, mst & ~spi & ~cout});
            check("R3 sda pull", {7'd0, sda_drive_low}, {7'd0, mst & ~spi & den & ~dout});
        end
        spi_en = 1'b0;

        // R4 data-in capture on the firmware clock rise
        for (int v = 0; v < 4; v++) begin
            logic lvl;
            lvl = v[0];
            sda_m = lvl;
            reg_write(2'd0, 8'b0000_1000);
            repeat (4) @(negedge clk);
            reg_write(2'd0, 8'b0010_1000);
            repeat (5) @(negedge clk);
            reg_read(2'd0, r);
            check("R4 capture", {7'd0, r[4]}, {7'd0, lvl});
            sda_m = ~lvl;
            repeat (5) @(negedge clk);
            reg_read(2'd0, r);
            check("R4 hold without edge", {7'd0, r[4]}, {7'd0, lvl});
            reg_write(2'd0, 8'b0100_1000);
            repeat (4) @(negedge clk);
            reg_write(2'd0, 8'b0110_1000);
            repeat (5) @(negedge clk);
            reg_read(2'd0, r);
            check("R4 hold with enable", {7'd0, r[4]}, {7'd0, lvl});
        end
        reg_write(2'd0, 8'h00);
        sda_m = 1'b1;
        scl_m = 1'b1;
        repeat (6) @(negedge clk);

        // R6 full address sweep
        for (int a = 0; a < 128; a++) begin
            addr_only(7'(a), ack);
            check("R6 address ack", {7'd0, ack}, {7'd0, (7'(a) == SELF7)});
        end

        // R8 R7 receive sweep
        bus_start();
        send_byte({SELF7, 1'b0}, ack);
        check("R6 write address ack", {7'd0, ack}, 8'h01);
        reg_read(2'd0, r);
        check("R7 direction receive", {7'd0, r[1]}, 8'h00);
        for (int k = 0; k < 16; k++) begin
            b = 8'(k * 17) ^ 8'h5A;
            send_byte(b, ack);
            check("R8 byte ack", {7'd0, ack}, 8'h01);
            reg_read(2'd2, r);
            check("R8 data", r, b);
            reg_read(2'd0, r);
            check("R8 flag set", {7'd0, r[0]}, 8'h01);
            reg_write(2'd0, 8'h01);
            reg_read(2'd0, r);
            check("R10 write one keeps flag", {7'd0, r[0]}, 8'h01);
            reg_write(2'd0, 8'h00);
            reg_read(2'd0, r);
            check("R10 flag cleared", {7'd0, r[0]}, 8'h00);
        end
        bus_stop();

        // R9 R7 transmit sweep
        reg_write(2'd2, 8'h05);
        bus_start();
        send_byte({SELF7, 1'b1}, ack);
        check("R6 read address ack", {7'd0, ack}, 8'h01);
        reg_read(2'd0, r);
        check("R7 direction transmit", {7'd0, r[1]}, 8'h01);
        for (int k = 0; k < 8; k++) begin
            logic last;
            last = (k == 7);
            recv_byte(r);
            check("R9 tx byte", r, 8'(k * 37 + 5));
            // acknowledge clock: master ACK except on the last byte
            @(negedge clk) sda_m = last;
            wait_q();
            scl_m = 1'b1;
            wait_q();
            reg_read(2'd0, r);
            check("R9 flag on ack clock", {7'd0, r[0]}, 8'h01);
            reg_write(2'd0, 8'h00);
            reg_write(2'd2, 8'((k + 1) * 37 + 5));
            wait_q();
            scl_m = 1'b0;
            wait_q();
        end
        xfer_bit(1'b1, s);
        check("R9 released after nack", {7'd0, s}, 8'h01);
        xfer_bit(1'b1, s);
        check("R9 still released", {7'd0, s}, 8'h01);
        bus_stop();

        // R5 no acknowledge while SPI owns the pins
        spi_en = 1'b1;
        addr_only(SELF7, ack);
        check("R5 spi blocks slave", {7'd0, ack}, 8'h00);
        spi_en = 1'b0;
        repeat (4) @(negedge clk);

        // R11 engine reset
        reg_write(2'd0, 8'h04);
        addr_only(SELF7, ack);
        check("R11 held engine silent", {7'd0, ack}, 8'h00);
        reg_write(2'd0, 8'h00);
        addr_only(SELF7, ack);
        check("R11 resumes", {7'd0, ack}, 8'h01);

        // R12 new own address
        reg_write(2'd1, 8'h7E);
        addr_only(7'h3F, ack);
        check("R12 new address ack", {7'd0, ack}, 8'h01);
        addr_only(SELF7, ack);
        check("R12 old address ignored", {7'd0, ack}, 8'h00);
        reg_write(2'd1, 8'h55);

        // R13 repeated start after a mismatch
        bus_start();
        send_byte({7'h11, 1'b0}, ack);
        check("R13 first address ignored", {7'd0, ack}, 8'h00);
        bus_restart();
        send_byte({SELF7, 1'b0}, ack);
        check("R13 restart address ack", {7'd0, ack}, 8'h01);
        send_byte(8'hC3, ack);
        reg_read(2'd2, r);
        check("R13 data after restart", r, 8'hC3);
        bus_stop();
        reg_write(2'd0, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule